// File: doc/BRIEF.md
# Sample-Reload DMA Cycle-Steal and Parity Tracker

This block models the stall that a sample-buffer reload DMA imposes on a CPU whose cycles alternate between a "get" phase and a "put" phase. On every clock the CPU side reports what kind of cycle it is running: a read, a write, a cycle inside a sprite-table DMA, or the last cycle of that sprite DMA. It also reports the bus address. A one-cycle request pulse asks for a reload fetch. The tracker picks how many cycles the fetch steals from that cycle kind and raises a halt for exactly that many cycles. It also keeps a running get/put parity bit.

A steal of odd length shifts the get/put phase of all the code that follows, and the tracker folds that shift into its parity bit. While the CPU is halted it may keep repeating a read of the joypad ports. Each such repeated read removes a bit from the controller's serial report. The tracker flags every halt cycle that coincides with a CPU read inside the joypad address window, so that timed read code can be checked against the stall pattern.

Top module: `pt_steal_tracker`

## Requirements
- R1: While reset is asserted, `halt_o` = 0, `steal_len_o` = 0, `parity_o` = 0 (get) and `conflict_o` = 0.
- R2: Parity encoding is 0 = get, 1 = put. When no request is accepted and the cycle kind is not sprite-end, `parity_o` inverts on every clock, halted cycles included.
- R3: Cycle kind encoding on `cyc_kind_i` is 0 = read, 1 = write, 2 = inside sprite DMA, 3 = sprite DMA end. A request accepted on a read cycle steals READ_STEAL (default 4) cycles.
- R4: A request accepted on a write cycle steals WR_ODD_STEAL (default 3) cycles if that write is at an odd position (1st, 3rd, ...) in the current run of back-to-back write cycles, and WR_EVEN_STEAL (default 4) cycles if it is at an even position. Any non-write cycle ends the run, and the run still advances during a halt.
- R5: A request accepted on a cycle inside sprite DMA steals SPR_STEAL (default 2, even) cycles.
- R6: A sprite-DMA-end cycle forces the parity of the next cycle to get. If a request is accepted on that cycle, the steal is END_STEAL (default 3) cycles long and the next parity is put.
- R7: A request is accepted when `dma_req_i` = 1 and `halt_o` = 0. On acceptance the next parity is the normal next parity XOR the least significant bit of the steal length.
- R8: A request that arrives while `halt_o` = 1 is ignored. It neither extends the halt nor changes `steal_len_o`.
- R9: `conflict_o` is 1 in the clock after a cycle in which `halt_o` = 1, the cycle kind is read and `cpu_addr_i` lies in [PORT_BASE, PORT_BASE+PORT_CNT). Default window is 0x4016..0x4017. Otherwise `conflict_o` is 0.
- R10: After an accepted request, `halt_o` is 1 for exactly the selected number of cycles, starting the next clock. `steal_len_o` holds that length from the first halted cycle until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_kind_i | input | 2 | Kind of the current CPU cycle (0 read, 1 write, 2 in sprite DMA, 3 sprite DMA end) |
| cpu_addr_i | input | ADDR_W | CPU bus address of the current cycle |
| dma_req_i | input | 1 | Reload fetch request pulse |
| halt_o | output | 1 | CPU halted by a steal |
| steal_len_o | output | LEN_W | Length of the most recently accepted steal |
| parity_o | output | 1 | Current cycle phase, 0 get, 1 put |
| conflict_o | output | 1 | A halted cycle overlapped a joypad-port read |

## Verification
The bench builds the tracker with its default parameters: a 16-bit address, a two-address joypad window at 0x4016, and steal lengths of 4, 3, 4, 2 and 3. With a three-bit length field, every steal length and the countdown fit without wrap. The odd lengths 3 make the phase inversion after write and sprite-end steals visible. Random addresses are drawn half of the time from a small set around the window. This puts both edges of the window (0x4015, 0x4018) and both ports within reach during halts, together with long write runs that reach odd and even positions.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [1:0] {
        CYC_READ    = 2'd0,
        CYC_WRITE   = 2'd1,
        CYC_SPR     = 2'd2,
        CYC_SPR_END = 2'd3
    } cyc_kind_e;

    localparam logic PAR_GET = 1'b0;
    localparam logic PAR_PUT = 1'b1;

endpackage

// File: rtl/pt_write_run.sv
// Tracks the position of the current cycle inside a run of back-to-back writes.
module pt_write_run (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic is_write_i,
    output logic pos_odd_o
);
    // run_odd: number of writes already seen in the current run is odd
    typedef struct packed {
        logic run_odd;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (is_write_i) begin
            run_d.run_odd = ~run_q.run_odd;
        end else begin
            run_d.run_odd = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // Current write sits at an odd position when an even count preceded it
    assign pos_odd_o = ~run_q.run_odd;

    // R4: a write after a write alternates the position
    a_r4_run_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_write_i && pos_odd_o) |=> (is_write_i |-> !pos_odd_o));
    a_r4_run_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !is_write_i |=> pos_odd_o);

endmodule

// File: rtl/pt_len_select.sv
// Picks the steal length for the cycle kind on which a request lands.
module pt_len_select
    import pt_pkg::*;
#(
    parameter int READ_STEAL    = 4,
    parameter int WR_ODD_STEAL  = 3,
    parameter int WR_EVEN_STEAL = 4,
    parameter int SPR_STEAL     = 2,
    parameter int END_STEAL     = 3,
    parameter int LEN_W         = 3
) (
    input  cyc_kind_e        kind_i,
    input  logic             wr_pos_odd_i,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [LEN_W-1:0] L_READ   = LEN_W'(READ_STEAL);
    localparam logic [LEN_W-1:0] L_WR_ODD = LEN_W'(WR_ODD_STEAL);
    localparam logic [LEN_W-1:0] L_WR_EVN = LEN_W'(WR_EVEN_STEAL);
    localparam logic [LEN_W-1:0] L_SPR    = LEN_W'(SPR_STEAL);
    localparam logic [LEN_W-1:0] L_END    = LEN_W'(END_STEAL);

    always_comb begin
        unique case (kind_i)
            CYC_READ:    len_o = L_READ;
            CYC_WRITE:   len_o = wr_pos_odd_i ? L_WR_ODD : L_WR_EVN;
            CYC_SPR:     len_o = L_SPR;
            CYC_SPR_END: len_o = L_END;
            default:     len_o = L_READ;
        endcase
    end

    always_comb begin
        a_r5_len_nonzero: assert (len_o != '0);
    end

endmodule

// File: rtl/pt_port_match.sv
// Decodes whether an address falls inside the joypad port window.
module pt_port_match #(
    parameter int ADDR_W    = 16,
    parameter int PORT_BASE = 'h4016,
    parameter int PORT_CNT  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(PORT_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(PORT_BASE + PORT_CNT);

    logic [ADDR_W:0] addr_ext;

    always_comb begin
        addr_ext = {1'b0, addr_i};
        hit_o    = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
    end

endmodule

// File: rtl/pt_steal_tracker.sv
// Reload-DMA steal length, halt window, get/put parity and joypad conflict.
module pt_steal_tracker
    import pt_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int PORT_BASE     = 'h4016,
    parameter int PORT_CNT      = 2,
    parameter int READ_STEAL    = 4,
    parameter int WR_ODD_STEAL  = 3,
    parameter int WR_EVEN_STEAL = 4,
    parameter int SPR_STEAL     = 2,
    parameter int END_STEAL     = 3,
    parameter int LEN_W         = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        cyc_kind_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              dma_req_i,
    output logic              halt_o,
    output logic [LEN_W-1:0]  steal_len_o,
    output logic              parity_o,
    output logic              conflict_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;   // halted cycles still to go
        logic [LEN_W-1:0] len;   // length of last accepted steal
        logic             par;   // get/put phase
        logic             conf;  // joypad conflict seen last cycle
    } trk_t;

    trk_t trk_d, trk_q;

    cyc_kind_e        kind;
    logic             wr_pos_odd;
    logic             port_hit;
    logic [LEN_W-1:0] sel_len;
    logic             halting;
    logic             accept;

    assign kind = cyc_kind_e'(cyc_kind_i);

    pt_write_run u_run (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .is_write_i (kind == CYC_WRITE),
        .pos_odd_o  (wr_pos_odd)
    );

    pt_len_select #(
        .READ_STEAL    (READ_STEAL),
        .WR_ODD_STEAL  (WR_ODD_STEAL),
        .WR_EVEN_STEAL (WR_EVEN_STEAL),
        .SPR_STEAL     (SPR_STEAL),
        .END_STEAL     (END_STEAL),
        .LEN_W         (LEN_W)
    ) u_len (
        .kind_i       (kind),
        .wr_pos_odd_i (wr_pos_odd),
        .len_o        (sel_len)
    );

    pt_port_match #(
        .ADDR_W    (ADDR_W),
        .PORT_BASE (PORT_BASE),
        .PORT_CNT  (PORT_CNT)
    ) u_port (
        .addr_i (cpu_addr_i),
        .hit_o  (port_hit)
    );

    always_comb begin
        trk_d   = trk_q;
        halting = (trk_q.cnt != '0);
        accept  = dma_req_i && !halting;

        trk_d.conf = halting && (kind == CYC_READ) && port_hit;
        trk_d.par  = (kind == CYC_SPR_END) ? PAR_GET : ~trk_q.par;

        if (accept) begin
            trk_d.cnt = sel_len;
            trk_d.len = sel_len;
            trk_d.par = trk_d.par ^ sel_len[0];
        end else if (halting) begin
            trk_d.cnt = trk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '{cnt: '0, len: '0, par: PAR_GET, conf: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign halt_o      = (trk_q.cnt != '0);
    assign steal_len_o = trk_q.len;
    assign parity_o    = trk_q.par;
    assign conflict_o  = trk_q.conf;

    // R2: plain cycles flip the phase
    a_r2_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!dma_req_i || halt_o) && kind != CYC_SPR_END) |=> parity_o != $past(parity_o));
    // R3: read-cycle request starts a halt of the read length
    a_r3_read_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_req_i && !halt_o && kind == CYC_READ) |=> (halt_o && steal_len_o == LEN_W'(READ_STEAL)));
    // R5: sprite-DMA request uses the sprite length
    a_r5_sprite_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_req_i && !halt_o && kind == CYC_SPR) |=> (halt_o && steal_len_o == LEN_W'(SPR_STEAL)));
    // R6: sprite end without a steal resyncs to get
    a_r6_end_get: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind == CYC_SPR_END && !(dma_req_i && !halt_o)) |=> parity_o == PAR_GET);
    // R7: an odd steal leaves the phase where it was
    a_r7_odd_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && sel_len[0] && kind != CYC_SPR_END) |=> parity_o == $past(parity_o));
    // R8: requests during a halt leave the length alone
    a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> $stable(steal_len_o));
    // R9: a conflict only follows a halted cycle
    a_r9_conflict_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conflict_o |-> $past(halt_o));
    // R10: a halt always carries a non-zero length
    a_r10_halt_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |-> steal_len_o != '0);

endmodule

// File: tb/sim_pt_steal_tracker.sv
module sim_pt_steal_tracker;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  cyc_kind_i = 2'd0;
    logic [15:0] cpu_addr_i = 16'h0000;
    logic        dma_req_i = 1'b0;
    logic        halt_o;
    logic [2:0]  steal_len_o;
    logic        parity_o;
    logic        conflict_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state after the next clock edge
    int e_cnt  = 0;
    int e_len  = 0;
    bit e_par  = 1'b0;
    bit e_conf = 1'b0;
    bit e_wodd = 1'b0;   // prior writes in current run is odd
    string last_tag = "R1";

    always #5 clk_i = ~clk_i;

    pt_steal_tracker u0 (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cyc_kind_i  (cyc_kind_i),
        .cpu_addr_i  (cpu_addr_i),
        .dma_req_i   (dma_req_i),
        .halt_o      (halt_o),
        .steal_len_o (steal_len_o),
        .parity_o    (parity_o),
        .conflict_o  (conflict_o)
    );

    function automatic int steal_of(input logic [1:0] k, input bit pos_odd);
        case (k)
            2'd0: return 4;
            2'd1: return pos_odd ? 3 : 4;
            2'd2: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic bit in_window(input logic [15:0] a);
        return (a == 16'h4016) || (a == 16'h4017);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk({last_tag, " R10"}, "halt", int'(halt_o), (e_cnt != 0) ? 1 : 0);
        chk({last_tag, " R3"},  "steal_len", int'(steal_len_o), e_len);
        chk({last_tag, " R2"},  "parity", int'(parity_o), int'(e_par));
        chk({last_tag, " R9"},  "conflict", int'(conflict_o), int'(e_conf));
    endtask

    task automatic step(input logic [1:0] k, input logic [15:0] a, input bit req, input string tag);
        bit halting;
        bit pos_odd;
        int l;
        @(negedge clk_i);
        check_outputs();
        rst_ni     = 1'b1;
        cyc_kind_i = k;
        cpu_addr_i = a;
        dma_req_i  = req;
        halting = (e_cnt != 0);
        pos_odd = !e_wodd;
        e_conf  = halting && (k == 2'd0) && in_window(a);
        e_par   = (k == 2'd3) ? 1'b0 : !e_par;
        if (req && !halting) begin
            l     = steal_of(k, pos_odd);
            e_len = l;
            e_cnt = l;
            e_par = e_par ^ l[0];
        end else if (halting) begin
            e_cnt = e_cnt - 1;
        end
        e_wodd   = (k == 2'd1) ? !e_wodd : 1'b0;
        last_tag = tag;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(2'd0, 16'h0300, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] nearby [4];
        nearby[0] = 16'h4015; nearby[1] = 16'h4016;
        nearby[2] = 16'h4017; nearby[3] = 16'h4018;
        void'($urandom(32'd20240823));

        repeat (3) @(negedge clk_i);
        last_tag = "R1";               // reset state checked at next step
        idle(4, "R2");

        // R3: read-cycle request, halt four cycles
        step(2'd0, 16'h0300, 1'b1, "R3");
        idle(6, "R3");

        // R4: odd and even positions in a write run
        step(2'd1, 16'h2000, 1'b1, "R4");   // first write -> 3
        idle(5, "R4");
        step(2'd1, 16'h2000, 1'b0, "R4");
        step(2'd1, 16'h2001, 1'b1, "R4");   // second write -> 4
        idle(6, "R4");
        step(2'd1, 16'h2000, 1'b0, "R4");
        step(2'd1, 16'h2000, 1'b0, "R4");
        step(2'd1, 16'h2000, 1'b1, "R7");   // third write -> 3, odd
        idle(5, "R4");

        // R5: during sprite DMA
        step(2'd2, 16'h4014, 1'b0, "R5");
        step(2'd2, 16'h4014, 1'b1, "R5");
        step(2'd2, 16'h4014, 1'b0, "R5");
        step(2'd2, 16'h4014, 1'b0, "R5");
        // R6: end without request forces get
        step(2'd3, 16'h4014, 1'b0, "R6");
        idle(3, "R6");
        // R6: end with request -> 3 and put
        step(2'd2, 16'h4014, 1'b0, "R6");
        step(2'd3, 16'h4014, 1'b1, "R6");
        idle(5, "R6");

        // R8: requests during a halt ignored
        step(2'd0, 16'h0300, 1'b1, "R8");
        step(2'd2, 16'h0300, 1'b1, "R8");
        step(2'd1, 16'h0300, 1'b1, "R8");
        step(2'd0, 16'h0300, 1'b1, "R8");
        step(2'd0, 16'h0300, 1'b0, "R8");
        idle(2, "R8");

        // R9: joypad reads during a halt, and window edges
        step(2'd0, 16'h0300, 1'b1, "R9");
        step(2'd0, 16'h4016, 1'b0, "R9");
        step(2'd0, 16'h4018, 1'b0, "R9");
        step(2'd0, 16'h4017, 1'b0, "R9");
        step(2'd1, 16'h4016, 1'b0, "R9");
        step(2'd0, 16'h4016, 1'b0, "R9");   // halt over, no conflict
        step(2'd0, 16'h4015, 1'b0, "R9");
        idle(2, "R9");

        // R10 and all rules: random cycle stream
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  k;
            logic [15:0] a;
            bit          r;
            int          pick;
            pick = int'($urandom_range(0, 9));
            k = (pick < 4) ? 2'd0 : (pick < 8) ? 2'd1 : (pick < 9) ? 2'd2 : 2'd3;
            a = ($urandom_range(0, 1) == 0) ? nearby[$urandom_range(0, 3)] : 16'($urandom());
            r = ($urandom_range(0, 5) == 0);
            step(k, a, r, "R10");
        end

        @(negedge clk_i);
        check_outputs();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule